// File: doc/BRIEF.md
# Run-Length Stream Expander

This block turns a compressed byte stream into its expanded form. A stream opens with a four-byte header: a type byte, then a 24-bit output length sent least significant byte first. Runs follow. Each run opens with a control byte. With its top bit set, one value byte follows and that value is written several times. With its top bit clear, a group of bytes follows and each is copied through once. Input bytes arrive on a valid/ready port and expanded data leaves on a second valid/ready port.

Output ends exactly at the declared length. A run that would go past it is cut short, and its unused input bytes are never taken. Zero bytes are then appended until the total is a whole number of 4-byte words. A mode input selects whether output leaves one byte per transfer or as 16-bit halfwords built from pairs of bytes.

A one-cycle done pulse marks the end of each stream, and streams may follow one another directly. A wrong type byte raises a sticky error.

Top module: `rle_unpack_top`

## Requirements
- R1: After reset, out_valid, done and err are 0 and in_ready is 1.
- R2: A stream starts with four header bytes. The first is the type byte and must be 0x30. The next three give the output length L, least significant byte first.
- R3: A control byte with bit 7 = 1 is followed by one value byte. That value is output (bits 6:0) + 3 times.
- R4: A control byte with bit 7 = 0 is followed by (bits 6:0) + 1 literal bytes. They are output in arrival order.
- R5: Once L bytes have been produced, the current run ends at once. None of its remaining input bytes is taken, and the next input byte is read as the type byte of the next stream.
- R6: After L bytes, (4 − L) mod 4 zero bytes are output.
- R7: cfg_half is sampled with the type byte. When it is 0, each transfer carries one byte in out_data[7:0], with out_data[15:8] = 0 and out_wide = 0. When it is 1, out_wide = 1 and each transfer carries two consecutive bytes: the earlier byte in [7:0] and the later byte in [15:8].
- R8: In halfword mode, padding first completes a pending half with a zero upper byte, then sends zero halfwords. The total is (L + pad) / 2 transfers.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data is unchanged. Under any stall pattern no byte is lost or duplicated.
- R10: done is a single-cycle pulse. It is raised only after the last transfer of a stream, and never while out_valid is 1. A stream with L = 0 produces no transfer and one done pulse.
- R11: A type byte other than 0x30 sets err. err then holds until reset, in_ready stays 0 and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | 1 | Halfword output mode, sampled with the type byte |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Compressed input byte |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| out_valid | output | 1 | Output transfer valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 16 | Output byte or halfword |
| out_wide | output | 1 | Transfer is a halfword |
| done | output | 1 | End-of-stream pulse |
| err | output | 1 | Sticky bad-type flag |

## Verification
The bench runs five kinds of stream:
- A single repeat run with a three-byte pad, which separates the +3 bias from the +1 bias and shows that padding is added.
- A pure literal run with length a multiple of four, which shows that no pad is added.
- Back-to-back streams whose repeat and literal runs both overrun the declared length. A decoder that takes even one extra input byte misreads the following header, so its output goes wrong.
- Halfword streams of odd length, which show that byte pairing and the pad path complete a pending half.
- A 256-byte stream and a zero-length stream, which exercise the middle length byte and the path that produces no output.

Output stalls and input gaps are mixed in throughout, to check that counts survive backpressure.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 4;
  localparam int CNT_W     = BYTE_W * (HDR_BYTES - 1);
  localparam int HIDX_W    = $clog2(HDR_BYTES);
  localparam int RUN_W     = 8;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_FLAG,
    ST_RVAL,
    ST_REP,
    ST_LIT,
    ST_PAD,
    ST_DONE,
    ST_ERR
  } rle_state_e;
endpackage

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TYPE_CODE = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_half,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              half_mode,
  output logic              emit_valid,
  output logic [BYTE_W-1:0] emit_byte,
  input  logic              emit_ready,
  input  logic              pack_idle,
  output logic              done,
  output logic              err
);

  rle_state_e        state_q;
  logic [CNT_W-1:0]  remain_q;
  logic [RUN_W-1:0]  run_q;
  logic [1:0]        pad_q;
  logic [HIDX_W-1:0] hidx_q;
  logic [BYTE_W-1:0] rep_q;
  logic              half_q;
  logic              done_q;
  logic              err_q;

  logic              in_fire;
  logic              emit_fire;
  logic [CNT_W-1:0]  cnt_full;
  logic [1:0]        pad_n;

  assign cnt_full  = {in_data, remain_q[CNT_W-1:BYTE_W]};
  assign pad_n     = 2'd0 - cnt_full[1:0];
  assign half_mode = half_q;
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    in_ready   = 1'b0;
    emit_valid = 1'b0;
    emit_byte  = '0;
    case (state_q)
      ST_HDR, ST_FLAG, ST_RVAL: in_ready = 1'b1;
      ST_REP: begin
        emit_valid = 1'b1;
        emit_byte  = rep_q;
      end
      ST_LIT: begin
        emit_valid = in_valid;
        emit_byte  = in_data;
        in_ready   = emit_ready;
      end
      ST_PAD:  emit_valid = 1'b1;
      default: ;
    endcase
  end

  assign in_fire   = in_valid && in_ready;
  assign emit_fire = emit_valid && emit_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_HDR;
      remain_q <= '0;
      run_q    <= '0;
      pad_q    <= '0;
      hidx_q   <= '0;
      rep_q    <= '0;
      half_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_HDR: if (in_fire) begin
          if (hidx_q == '0) begin
            if (in_data != TYPE_CODE) begin
              err_q   <= 1'b1;
              state_q <= ST_ERR;
            end else begin
              half_q <= cfg_half;
              hidx_q <= hidx_q + 1'b1;
            end
          end else begin
            remain_q <= cnt_full;
            if (hidx_q == HIDX_W'(HDR_BYTES - 1)) begin
              hidx_q  <= '0;
              pad_q   <= pad_n;
              state_q <= (cnt_full == '0) ? ST_DONE : ST_FLAG;
            end else begin
              hidx_q <= hidx_q + 1'b1;
            end
          end
        end
        ST_FLAG: if (in_fire) begin
          if (in_data[BYTE_W-1]) begin
            run_q   <= RUN_W'(in_data[BYTE_W-2:0]) + RUN_W'(3);
            state_q <= ST_RVAL;
          end else begin
            run_q   <= RUN_W'(in_data[BYTE_W-2:0]) + RUN_W'(1);
            state_q <= ST_LIT;
          end
        end
        ST_RVAL: if (in_fire) begin
          rep_q   <= in_data;
          state_q <= ST_REP;
        end
        ST_REP, ST_LIT: if (emit_fire) begin
          remain_q <= remain_q - 1'b1;
          run_q    <= run_q - 1'b1;
          if (remain_q == CNT_W'(1))
            state_q <= (pad_q != 2'd0) ? ST_PAD : ST_DONE;
          else if (run_q == RUN_W'(1))
            state_q <= ST_FLAG;
        end
        ST_PAD: if (emit_fire) begin
          pad_q <= pad_q - 1'b1;
          if (pad_q == 2'd1) state_q <= ST_DONE;
        end
        ST_DONE: if (pack_idle) begin
          done_q  <= 1'b1;
          state_q <= ST_HDR;
        end
        default: state_q <= ST_ERR;
      endcase
    end
  end

endmodule

// File: rtl/rle_pack.sv
module rle_pack
  import rle_pkg::*;
#(
  parameter int OUT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_mode,
  input  logic              emit_valid,
  input  logic [BYTE_W-1:0] emit_byte,
  output logic              emit_ready,
  output logic              pack_idle,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_wide
);

  logic              out_valid_q;
  logic [OUT_W-1:0]  out_data_q;
  logic              out_wide_q;
  logic              have_lo_q;
  logic [BYTE_W-1:0] lo_q;
  logic              slot_free;
  logic              take_lo;

  assign slot_free  = !out_valid_q || out_ready;
  assign take_lo    = half_mode && !have_lo_q;
  assign emit_ready = take_lo ? 1'b1 : slot_free;
  assign pack_idle  = !out_valid_q && !have_lo_q;
  assign out_valid  = out_valid_q;
  assign out_data   = out_data_q;
  assign out_wide   = out_wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_wide_q  <= 1'b0;
      have_lo_q   <= 1'b0;
      lo_q        <= '0;
    end else begin
      if (out_valid_q && out_ready) out_valid_q <= 1'b0;
      if (emit_valid && emit_ready) begin
        if (take_lo) begin
          lo_q      <= emit_byte;
          have_lo_q <= 1'b1;
        end else begin
          out_valid_q <= 1'b1;
          out_wide_q  <= half_mode;
          out_data_q  <= half_mode ? {emit_byte, lo_q}
                                   : OUT_W'(emit_byte);
          have_lo_q   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rle_unpack_top.sv
module rle_unpack_top
  import rle_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TYPE_CODE = 8'h30,
  parameter int                OUT_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_half,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_wide,
  output logic              done,
  output logic              err
);

  logic              half_mode;
  logic              emit_valid;
  logic [BYTE_W-1:0] emit_byte;
  logic              emit_ready;
  logic              pack_idle;

  rle_ctrl #(.TYPE_CODE(TYPE_CODE)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfg_half   (cfg_half),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .half_mode  (half_mode),
    .emit_valid (emit_valid),
    .emit_byte  (emit_byte),
    .emit_ready (emit_ready),
    .pack_idle  (pack_idle),
    .done       (done),
    .err        (err)
  );

  rle_pack #(.OUT_W(OUT_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .half_mode  (half_mode),
    .emit_valid (emit_valid),
    .emit_byte  (emit_byte),
    .emit_ready (emit_ready),
    .pack_idle  (pack_idle),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_wide   (out_wide)
  );

endmodule

// File: rtl/rle_unpack_chk.sv
module rle_unpack_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_wide,
  input logic             done,
  input logic             err
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid); // R9
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_data)); // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R11
  AST_ERR_BLOCK: assert property (@(posedge clk) disable iff (rst)
    err |-> !in_ready && !out_valid); // R11
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_wide |-> out_data[OUT_W-1:OUT_W/2] == '0); // R7

endmodule

bind rle_unpack_top rle_unpack_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_wide  (out_wide),
  .done      (done),
  .err       (err)
);

// File: tb/tb_rle_unpack_top.sv
`timescale 1ns/1ps
module tb_rle_unpack_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_half = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_wide;
  logic        done;
  logic        err;

  int n_checks = 0;
  int n_fail   = 0;
  int ns = 0;
  int ne = 0;
  logic [7:0]  src   [0:511];
  logic [15:0] exp_d [0:511];
  logic        exp_w [0:511];
  logic [15:0] got_d [0:511];
  logic        got_w [0:511];

  always #10 clk = ~clk;

  rle_unpack_top dut (
    .clk(clk), .rst(rst), .cfg_half(cfg_half),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_wide(out_wide), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  task automatic clear();
    ns = 0;
    ne = 0;
  endtask

  task automatic s(input logic [7:0] b);
    src[ns] = b;
    ns++;
  endtask

  task automatic hdr(input int len);
    s(8'h30); s(len[7:0]); s(len[15:8]); s(len[23:16]);
  endtask

  task automatic eb(input logic [7:0] b);
    exp_d[ne] = {8'h00, b};
    exp_w[ne] = 1'b0;
    ne++;
  endtask

  task automatic eh(input logic [15:0] h);
    exp_d[ne] = h;
    exp_w[ne] = 1'b1;
    ne++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic run_case(input string req, input int ndone,
                          input int stall, input int gap);
    int ii = 0;
    int no = 0;
    int nd = 0;
    int cyc = 0;
    bit hold = 1'b0;
    logic [15:0] hold_d = '0;
    while ((ii < ns || nd < ndone) && cyc < 4000) begin
      in_valid  = (ii < ns) && !(gap > 0 && (cyc % gap) == gap - 1);
      in_data   = (ii < ns) ? src[ii] : 8'h00;
      out_ready = !(stall > 0 && (cyc % stall) == stall - 1);
      @(negedge clk);
      if (hold)
        chk(out_valid && out_data == hold_d, "R9", "stalled output changed",
            {15'd0, out_valid, out_data}, {16'd1, hold_d});
      hold = out_valid && !out_ready;
      hold_d = out_data;
      if (in_valid && in_ready) ii++;
      if (out_valid && out_ready) begin
        if (no < 512) begin got_d[no] = out_data; got_w[no] = out_wide; end
        no++;
      end
      if (done) nd++;
      @(posedge clk);
      #1;
      cyc++;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (out_valid) no++;
      if (done) nd++;
      @(posedge clk);
      #1;
    end
    chk(cyc < 4000, req, "stream did not complete", cyc, 4000);
    chk(no == ne, req, "output transfer count", no, ne);
    chk(nd == ndone, "R10", "done pulse count", nd, ndone);
    for (int k = 0; k < ne && k < no; k++)
      chk(got_d[k] == exp_d[k] && got_w[k] == exp_w[k], req,
          $sformatf("transfer %0d data/wide", k),
          {15'd0, got_w[k], got_d[k]}, {15'd0, exp_w[k], exp_d[k]});
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(!done, "R1", "done after reset", done, 0);
    chk(!err, "R1", "err after reset", err, 0);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);
    @(posedge clk);
    #1;
  endtask

  // R2 R3 R6: repeat run, length 5, pad 3
  task automatic t_repeat();
    clear();
    cfg_half = 1'b0;
    hdr(5); s(8'h82); s(8'hA5);
    repeat (5) eb(8'hA5);
    repeat (3) eb(8'h00);
    run_case("R3", 1, 0, 3);
  endtask

  // R4 R6 R9: literal run, length 4, no pad, output stalls
  task automatic t_literal();
    clear();
    cfg_half = 1'b0;
    hdr(4); s(8'h03); s(8'h11); s(8'h22); s(8'h33); s(8'h44);
    eb(8'h11); eb(8'h22); eb(8'h33); eb(8'h44);
    run_case("R4", 1, 2, 0);
  endtask

  // R5: overrunning repeat and literal runs, streams back to back
  task automatic t_cut();
    clear();
    cfg_half = 1'b0;
    hdr(6); s(8'h01); s(8'hAA); s(8'hBB); s(8'h85); s(8'hCC);
    eb(8'hAA); eb(8'hBB);
    repeat (4) eb(8'hCC);
    repeat (2) eb(8'h00);
    hdr(2); s(8'h05); s(8'h01); s(8'h02);
    eb(8'h01); eb(8'h02); eb(8'h00); eb(8'h00);
    hdr(1); s(8'h80); s(8'h77);
    eb(8'h77); repeat (3) eb(8'h00);
    run_case("R5", 3, 3, 2);
  endtask

  // R7 R8: halfword mode, odd lengths
  task automatic t_half();
    clear();
    cfg_half = 1'b1;
    hdr(3); s(8'h02); s(8'h12); s(8'h34); s(8'h56);
    eh(16'h3412); eh(16'h0056);
    hdr(5); s(8'h82); s(8'h9C);
    eh(16'h9C9C); eh(16'h9C9C); eh(16'h009C); eh(16'h0000);
    run_case("R8", 2, 2, 0);
    cfg_half = 1'b0;
  endtask

  // R2: length 256 uses the middle length byte
  task automatic t_long();
    clear();
    cfg_half = 1'b0;
    hdr(256); s(8'hFF); s(8'hAB); s(8'hFF); s(8'hAB);
    for (int k = 0; k < 256; k++) eb(8'hAB);
    run_case("R2", 1, 4, 0);
  endtask

  // R10: zero length
  task automatic t_zero();
    clear();
    hdr(0);
    run_case("R10", 1, 0, 0);
  endtask

  // R11: bad type byte
  task automatic t_error();
    in_valid = 1'b1;
    in_data  = 8'h31;
    @(negedge clk);
    chk(in_ready, "R11", "type byte accepted", in_ready, 1);
    @(posedge clk);
    #1;
    in_data = 8'h30;
    repeat (5) begin
      @(negedge clk);
      chk(err && !in_ready && !out_valid, "R11", "err/in_ready/out_valid",
          {err, in_ready, out_valid}, 3'b100);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    t_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_repeat();
    t_literal();
    t_cut();
    t_half();
    t_long();
    t_zero();
    t_error();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule